// File: doc/BRIEF.md
# Machine-Error Fault Register with Abort Pulse

This block collects hardware fault indications into a 16-bit sticky register. Every rising edge of `clk` is one sample point of the system sync clock. At each sample point the active-low fault lines are captured into fixed bit positions. Some lines set one bit. The system fault line sets two bits. The address-error line and the bus-timeout event each set one of two bits, and which one depends on whether the current bus cycle is a memory access or an IO access. Bits stay set until software clears them with a strobe and a bit mask.

Three bits are machine-error bits: 0, 5 and 8. When one of them goes from 0 to 1, the block sends an active-low abort pulse to the instruction sequencer. The pulse starts one sample point later and lasts exactly one period. While a DMA grant or a hold acknowledge is active, the address-error bits (5 and 8) cannot be set, and no abort pulse is issued. Interrupt priority and vectoring are handled elsewhere and read the register through `flt_q`.

Top module: `fault_reg_abort`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `flt_q` is 0 and `abort_n` is 1.
- R2: At an edge, a low on `prim_flt_n` sets bit 0, a low on `dma_par_n` sets bit 4, a low on `io_xfer_n` sets bit 6, and a low on `spare_n` sets bit 7. Bits 1-3, 9-12 and 14 never become 1.
- R3: At an edge, a low on `ext_addr_n` sets bit 5 when `mem_sel` is 0 (IO cycle) and bit 8 when `mem_sel` is 1 (memory cycle).
- R4: At an edge, a high on `bus_tmo` sets bit 5 or bit 8, using the same `mem_sel` rule as R3.
- R5: At an edge, a low on `sys_flt_n` sets both bit 13 and bit 15.
- R6: While `dma_ack_n` or `hold_ack_n` is low at an edge, bits 5 and 8 are not set by that edge. The other bits are still captured.
- R7: A bit that is set stays set. At an edge where `clr_stb` is 1, every bit whose `clr_mask` bit is 1 is cleared. A fault and a clear on the same bit at the same edge leave the bit set.
- R8: If bit 0, 5 or 8 changes from 0 to 1 at edge k, `abort_n` is 0 from edge k+1 until edge k+2, which is exactly one period.
- R9: A fault on bit 0, 5 or 8 while that bit is already 1 does not start an abort pulse.
- R10: If `dma_ack_n` or `hold_ack_n` is low at edge k+1, the pulse that R8 would start there is dropped, and `abort_n` stays 1.
- R11: A 0-to-1 change of bits 4, 6, 7, 13 or 15 never drives `abort_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sync-clock sample edge (rising) |
| rst | input | 1 | Synchronous reset, active high |
| prim_flt_n | input | 1 | Primary machine fault, active low, sets bit 0 |
| dma_par_n | input | 1 | DMA parity error, active low, sets bit 4 |
| ext_addr_n | input | 1 | External address error, active low, sets bit 5 or 8 |
| io_xfer_n | input | 1 | IO transfer error, active low, sets bit 6 |
| spare_n | input | 1 | Spare fault, active low, sets bit 7 |
| sys_flt_n | input | 1 | System built-in test fault, active low, sets bits 13 and 15 |
| mem_sel | input | 1 | 1 for a memory cycle, 0 for an IO cycle |
| bus_tmo | input | 1 | Bus-timeout event, active high, sets bit 5 or 8 |
| dma_ack_n | input | 1 | DMA grant, active low |
| hold_ack_n | input | 1 | Hold acknowledge, active low |
| clr_stb | input | 1 | Software clear strobe |
| clr_mask | input | 16 | Bits to clear while `clr_stb` is 1 |
| flt_q | output | 16 | Fault register contents |
| abort_n | output | 1 | Machine-error abort pulse, active low |

## Verification
The hardest case to reach is a watched bit rising at one edge while a DMA grant or hold acknowledge becomes active at the next edge. In that case the bit has latched but its pulse must be dropped. A directed sequence builds this case, and so does a random run in which the acknowledges and the clear strobe change often and independently of the fault lines. Two other cases are also driven on purpose:
- a clear and a new fault on the same bit at the same edge;
- a retrigger on a bit that is already set.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int FR_W = 16;

    // Bit positions decoded by the interrupt logic that reads the register
    localparam int B_PRIM   = 0;
    localparam int B_DPAR   = 4;
    localparam int B_IOADR  = 5;
    localparam int B_IOXF   = 6;
    localparam int B_SPARE  = 7;
    localparam int B_MEMADR = 8;
    localparam int B_SYS_LO = 13;
    localparam int B_SYS_HI = 15;

    // Fault events at one sample point, active high inside the block
    typedef struct packed {
        logic prim;
        logic dpar;
        logic addr;
        logic ioxf;
        logic spare;
        logic sys;
        logic tmo;
        logic mem;
    } flt_evt_t;

    function automatic logic [FR_W-1:0] abort_bits();
        logic [FR_W-1:0] m;
        m = '0;
        m[B_PRIM]   = 1'b1;
        m[B_IOADR]  = 1'b1;
        m[B_MEMADR] = 1'b1;
        return m;
    endfunction

    function automatic logic [FR_W-1:0] set_vector(flt_evt_t e, logic blocked);
        logic [FR_W-1:0] v;
        logic addr_ev;
        v = '0;
        v[B_PRIM]   = e.prim;
        v[B_DPAR]   = e.dpar;
        v[B_IOXF]   = e.ioxf;
        v[B_SPARE]  = e.spare;
        v[B_SYS_LO] = e.sys;
        v[B_SYS_HI] = e.sys;
        addr_ev = (e.addr | e.tmo) & ~blocked;
        v[B_IOADR]  = addr_ev & ~e.mem;
        v[B_MEMADR] = addr_ev & e.mem;
        return v;
    endfunction

endpackage

// File: rtl/fr_source_map.sv
module fr_source_map
    import fr_pkg::*;
#(
    parameter int W = FR_W
) (
    input  flt_evt_t       evt,
    input  logic           blocked,
    output logic [W-1:0]   set_v
);

    always_comb begin
        set_v = set_vector(evt, blocked);
    end

endmodule

// File: rtl/fr_store.sv
module fr_store #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   set_v,
    input  logic           clr_stb,
    input  logic [W-1:0]   clr_mask,
    output logic [W-1:0]   q,
    output logic [W-1:0]   rise
);

    logic [W-1:0] q_nx;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            q_nx[i] = set_v[i] | (q[i] & ~(clr_stb & clr_mask[i]));
            rise[i] = q_nx[i] & ~q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) q[i] <= 1'b0;
            else     q[i] <= q_nx[i];
        end
    end

    // R7: without a clear strobe no set bit is lost
    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> ((q & $past(q)) == $past(q)));

    // R7: a bit requested by a source is set after the edge even under clear
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(set_v)) == $past(set_v)));

endmodule

// File: rtl/fr_abort.sv
module fr_abort #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    MASK = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [W-1:0]   rise,
    input  logic           blocked,
    output logic           abort_n
);

    logic pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            abort_n <= 1'b1;
        end else begin
            pend    <= |(rise & MASK);
            abort_n <= ~(pend & ~blocked);
        end
    end

    // R8/R11: a low abort comes from a watched bit rising two edges earlier
    assert_abort_cause_R8: assert property (@(posedge clk) disable iff (rst)
        !abort_n |-> $past(|(rise & MASK), 2));

    // R10: no pulse is issued while a grant or hold was active at its edge
    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !abort_n |-> !$past(blocked));

endmodule

// File: rtl/fault_reg_abort.sv
module fault_reg_abort
    import fr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               prim_flt_n,
    input  logic               dma_par_n,
    input  logic               ext_addr_n,
    input  logic               io_xfer_n,
    input  logic               spare_n,
    input  logic               sys_flt_n,
    input  logic               mem_sel,
    input  logic               bus_tmo,
    input  logic               dma_ack_n,
    input  logic               hold_ack_n,
    input  logic               clr_stb,
    input  logic [FR_W-1:0]    clr_mask,
    output logic [FR_W-1:0]    flt_q,
    output logic               abort_n
);

    localparam int              W     = FR_W;
    localparam logic [W-1:0]    AMASK = abort_bits();

    flt_evt_t     evt;
    logic         blocked;
    logic [W-1:0] set_v;
    logic [W-1:0] rise;

    always_comb begin
        evt.prim  = ~prim_flt_n;
        evt.dpar  = ~dma_par_n;
        evt.addr  = ~ext_addr_n;
        evt.ioxf  = ~io_xfer_n;
        evt.spare = ~spare_n;
        evt.sys   = ~sys_flt_n;
        evt.tmo   = bus_tmo;
        evt.mem   = mem_sel;
        blocked   = ~dma_ack_n | ~hold_ack_n;
    end

    fr_source_map #(.W(W)) u_map (
        .evt     (evt),
        .blocked (blocked),
        .set_v   (set_v)
    );

    fr_store #(.W(W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .set_v    (set_v),
        .clr_stb  (clr_stb),
        .clr_mask (clr_mask),
        .q        (flt_q),
        .rise     (rise)
    );

    fr_abort #(.W(W), .MASK(AMASK)) u_abort (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .blocked (blocked),
        .abort_n (abort_n)
    );

    // R6: address-error bits do not rise across an edge with grant or hold active
    assert_addr_block_R6: assert property (@(posedge clk) disable iff (rst)
        blocked |=> !(flt_q[B_IOADR] && !$past(flt_q[B_IOADR]))
                 && !(flt_q[B_MEMADR] && !$past(flt_q[B_MEMADR])));

    // R5: system fault sets both of its bits
    assert_sys_pair_R5: assert property (@(posedge clk) disable iff (rst)
        !sys_flt_n |=> (flt_q[B_SYS_LO] && flt_q[B_SYS_HI]));

    // R3: memory-cycle address error lands on bit 8
    assert_mem_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!ext_addr_n && mem_sel && !blocked) |=> flt_q[B_MEMADR]);

    // R3: IO-cycle address error lands on bit 5
    assert_io_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!ext_addr_n && !mem_sel && !blocked) |=> flt_q[B_IOADR]);

endmodule

// File: tb/sim_fault_reg_abort.sv
module sim_fault_reg_abort;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prim_flt_n, dma_par_n, ext_addr_n, io_xfer_n, spare_n, sys_flt_n;
    logic        mem_sel, bus_tmo, dma_ack_n, hold_ack_n, clr_stb;
    logic [15:0] clr_mask;
    logic [15:0] flt_q;
    logic        abort_n;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [15:0] mq;
    logic        mpend;
    logic        mabort;

    always #2 clk = ~clk;

    fault_reg_abort u0 (
        .clk(clk), .rst(rst),
        .prim_flt_n(prim_flt_n), .dma_par_n(dma_par_n), .ext_addr_n(ext_addr_n),
        .io_xfer_n(io_xfer_n), .spare_n(spare_n), .sys_flt_n(sys_flt_n),
        .mem_sel(mem_sel), .bus_tmo(bus_tmo), .dma_ack_n(dma_ack_n),
        .hold_ack_n(hold_ack_n), .clr_stb(clr_stb), .clr_mask(clr_mask),
        .flt_q(flt_q), .abort_n(abort_n)
    );

    function automatic logic [15:0] exp_set(logic blk);
        logic [15:0] v;
        v = '0;
        v[0]  = ~prim_flt_n;
        v[4]  = ~dma_par_n;
        v[6]  = ~io_xfer_n;
        v[7]  = ~spare_n;
        v[13] = ~sys_flt_n;
        v[15] = ~sys_flt_n;
        if ((~ext_addr_n | bus_tmo) & ~blk) begin
            if (mem_sel) v[8] = 1'b1;
            else         v[5] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        prim_flt_n = 1; dma_par_n = 1; ext_addr_n = 1; io_xfer_n = 1;
        spare_n = 1; sys_flt_n = 1; mem_sel = 0; bus_tmo = 0;
        dma_ack_n = 1; hold_ack_n = 1; clr_stb = 0; clr_mask = '0;
    endtask

    // One sample edge: model update, then compare both outputs
    task automatic tick(input string tag);
        logic        blk;
        logic [15:0] nq;
        logic [15:0] rs;
        blk = ~dma_ack_n | ~hold_ack_n;
        nq  = (mq & ~(clr_stb ? clr_mask : 16'h0)) | exp_set(blk);
        rs  = nq & ~mq & 16'h0121;
        @(posedge clk);
        #1;
        mabort = ~(mpend & ~blk);
        mpend  = |rs;
        mq     = nq;
        chk({tag, " reg"}, flt_q, mq);
        chk({tag, " abort"}, {15'd0, abort_n}, {15'd0, mabort});
        idle();
    endtask

    task automatic clear_all();
        clr_stb = 1; clr_mask = 16'hFFFF;
        tick("R7 clear");
        tick("R7 settle");
    endtask

    initial begin
        idle();
        mq = '0; mpend = 1'b0; mabort = 1'b1;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset reg", flt_q, 16'h0);
        chk("R1 reset abort", {15'd0, abort_n}, 16'h1);
        rst = 1'b0;
        tick("R1 first edge");
        chk("R1 after release", flt_q, 16'h0);

        // R2 + R8: primary fault, pulse one cycle later, one period wide
        prim_flt_n = 0; tick("R2 prim");
        chk("R2 bit0", flt_q, 16'h0001);
        chk("R8 not yet", {15'd0, abort_n}, 16'h1);
        tick("R8 pulse");
        chk("R8 abort low", {15'd0, abort_n}, 16'h0);
        tick("R8 end");
        chk("R8 one period", {15'd0, abort_n}, 16'h1);

        // R9: retrigger on a set bit
        prim_flt_n = 0; tick("R9 again");
        tick("R9 wait");
        chk("R9 no retrigger", {15'd0, abort_n}, 16'h1);
        clear_all();
        chk("R7 cleared", flt_q, 16'h0);

        // R3: IO and memory selection
        ext_addr_n = 0; mem_sel = 0; tick("R3 io");
        chk("R3 bit5", flt_q, 16'h0020);
        tick("R3 pulse");
        chk("R8 abort from bit5", {15'd0, abort_n}, 16'h0);
        clear_all();
        ext_addr_n = 0; mem_sel = 1; tick("R3 mem");
        chk("R3 bit8", flt_q, 16'h0100);
        clear_all();

        // R4: bus timeout
        bus_tmo = 1; mem_sel = 1; tick("R4 mem");
        chk("R4 bit8", flt_q, 16'h0100);
        clear_all();
        bus_tmo = 1; mem_sel = 0; tick("R4 io");
        chk("R4 bit5", flt_q, 16'h0020);
        clear_all();

        // R5 + R11: system fault, no abort
        sys_flt_n = 0; tick("R5 sys");
        chk("R5 bits 13 15", flt_q, 16'hA000);
        tick("R11 wait");
        chk("R11 no abort sys", {15'd0, abort_n}, 16'h1);
        clear_all();

        // R2 + R11: other single-bit lines
        dma_par_n = 0; io_xfer_n = 0; spare_n = 0; tick("R2 group");
        chk("R2 bits 4 6 7", flt_q, 16'h00D0);
        tick("R11 wait2");
        chk("R11 no abort group", {15'd0, abort_n}, 16'h1);
        clear_all();

        // R6: blocked by grant, then by hold; other bits still latch
        dma_ack_n = 0; ext_addr_n = 0; bus_tmo = 1; spare_n = 0; tick("R6 dma");
        chk("R6 dma block", flt_q, 16'h0080);
        hold_ack_n = 0; ext_addr_n = 0; mem_sel = 1; tick("R6 hold");
        chk("R6 hold block", flt_q, 16'h0080);
        clear_all();

        // R7: clear and set on the same bit at the same edge
        prim_flt_n = 0; tick("R7 set");
        tick("R7 pulse");
        prim_flt_n = 0; clr_stb = 1; clr_mask = 16'h0001; tick("R7 race");
        chk("R7 set wins", flt_q, 16'h0001);
        clr_stb = 1; clr_mask = 16'h0010; tick("R7 other mask");
        chk("R7 unmasked kept", flt_q, 16'h0001);
        clear_all();

        // R10: bit latches, grant active at the emit edge
        prim_flt_n = 0; tick("R10 latch");
        dma_ack_n = 0; tick("R10 emit");
        chk("R10 suppressed", {15'd0, abort_n}, 16'h1);
        tick("R10 after");
        chk("R10 stays high", {15'd0, abort_n}, 16'h1);
        clear_all();

        // Random mix, every cycle compared against the model (R2..R11)
        for (int n = 0; n < 3000; n++) begin
            prim_flt_n = ($urandom % 12) != 0;
            dma_par_n  = ($urandom % 10) != 0;
            ext_addr_n = ($urandom % 9) != 0;
            io_xfer_n  = ($urandom % 10) != 0;
            spare_n    = ($urandom % 10) != 0;
            sys_flt_n  = ($urandom % 14) != 0;
            mem_sel    = $urandom % 2;
            bus_tmo    = ($urandom % 11) == 0;
            dma_ack_n  = ($urandom % 6) != 0;
            hold_ack_n = ($urandom % 7) != 0;
            clr_stb    = ($urandom % 5) == 0;
            clr_mask   = 16'($urandom);
            tick("R8 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule